// File: doc/BRIEF.md
# Multi-Set Character Generator Addresser

This block forms the address and chip-select for a dot-pattern character ROM in a text display. On each character-clock enable it registers a character code from the line buffer, the current scan-line count, an enhancement attribute bit and the configured ROM size. From these it produces the ROM address and an active-low chip select one enable later.

The low seven code bits give the glyph index within a set, and the scan-line count gives the row of the glyph. Two further bits pick the character set: code bit 7 and the inverted enhancement bit. Their role depends on the configured ROM size. A 2K part holds one set, a 4K part holds two and an 8K part holds four. In every size the first address bit above the part's width becomes the active-low chip select. In the full-width size the chip is always selected.

Top module: `chargen_addresser`

## Requirements
- R1: While `rst` is high at a clock edge, `rom_addr` becomes 0 and `rom_cs_n` becomes 1.
- R2: At an edge where `char_en` is low and `rst` is low, `rom_addr` and `rom_cs_n` keep their values.
- R3: At the edge after `char_en` is high, `rom_addr[6:0]` equals the sampled `code_in[6:0]` and `rom_addr[10:7]` equals the sampled `scan_line`.
- R4: With `rom_size` = 0 (2K) at the loading edge, `rom_addr[12:11]` is 0 and `rom_cs_n` equals the sampled `code_in[7]`.
- R5: With `rom_size` = 1 (4K), `rom_addr[11]` equals `code_in[7]`, `rom_addr[12]` is 0, and `rom_cs_n` equals the inverse of `enh_in`.
- R6: With `rom_size` = 2 (8K), `rom_addr[12]` equals the inverse of `enh_in`, `rom_addr[11]` equals `code_in[7]`, and `rom_cs_n` is 0.
- R7: `rom_size` = 3 behaves exactly as `rom_size` = 2.
- R8: A change of `rom_size`, `code_in`, `enh_in` or `scan_line` while `char_en` is low has no effect on the outputs until the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_en | input | 1 | Character-clock enable; loads a new address |
| code_in | input | 8 | Character code from the line buffer |
| enh_in | input | 1 | Enhancement attribute bit (inverted to form the top set bit) |
| scan_line | input | 4 | Scan-line count within the character row |
| rom_size | input | 2 | ROM size: 0 = 2K, 1 = 4K, 2 or 3 = 8K |
| rom_addr | output | 13 | Registered character ROM address |
| rom_cs_n | output | 1 | Registered active-low ROM chip select |

## Verification
The hardest case to reach is a change of ROM size or attribute between enable pulses. In that case the held output must still reflect the size that was sampled at the last load. The stimulus therefore leaves `char_en` low for random stretches while it changes `rom_size`, `enh_in` and the code. It also runs every size, including the unused encoding, with both polarities of code bit 7 and the enhancement bit. A behavioural model computes the expected address arithmetically from the size and compares it on every clock.

// File: rtl/chargen_pkg.sv
package chargen_pkg;
  // ROM size selector; the unused code behaves as the widest part
  typedef enum logic [1:0] {
    ROM_ONE_SET  = 2'd0,
    ROM_TWO_SET  = 2'd1,
    ROM_FOUR_SET = 2'd2,
    ROM_WIDE_ALT = 2'd3
  } rom_size_e;

  localparam int SIZE_W   = 2;
  localparam int SET_BITS = 2;  // code bit 7 and inverted enhancement bit

  // number of set-select bits a size setting uses as address bits
  function automatic logic [SIZE_W-1:0] set_bits_used(input logic [SIZE_W-1:0] sz);
    if (sz > SIZE_W'(SET_BITS)) return SIZE_W'(SET_BITS);
    return sz;
  endfunction
endpackage

// File: rtl/chargen_addr_compose.sv
module chargen_addr_compose #(
  parameter int CODE_W = 8,
  parameter int LINE_W = 4,
  localparam int GLYPH_W = CODE_W - 1,
  localparam int BASE_W  = GLYPH_W + LINE_W,
  localparam int FULL_W  = BASE_W + chargen_pkg::SET_BITS
) (
  input  logic [CODE_W-1:0] code,
  input  logic              enh,
  input  logic [LINE_W-1:0] line,
  output logic [FULL_W-1:0] full_addr
);
  // order from low to high: glyph index, scan line, code set bit, enhancement set bit
  always_comb begin
    full_addr = {~enh, code[CODE_W-1], line, code[GLYPH_W-1:0]};
  end
endmodule

// File: rtl/chargen_size_mask.sv
module chargen_size_mask
  import chargen_pkg::*;
#(
  parameter int BASE_W = 11,
  localparam int FULL_W = BASE_W + SET_BITS
) (
  input  logic [FULL_W-1:0] full_addr,
  input  logic [SIZE_W-1:0] size_sel,
  output logic [FULL_W-1:0] rom_addr,
  output logic              cs_n
);
  logic [SIZE_W-1:0] used;

  always_comb used = set_bits_used(size_sel);

  assign rom_addr[BASE_W-1:0] = full_addr[BASE_W-1:0];

  // each set bit is an address bit only when the size covers it
  genvar k;
  generate
    for (k = 0; k < SET_BITS; k++) begin : g_set
      assign rom_addr[BASE_W+k] = (used > SIZE_W'(k)) ? full_addr[BASE_W+k] : 1'b0;
    end
  endgenerate

  // first set bit above the part's width becomes the chip select
  always_comb begin
    cs_n = 1'b0;
    for (int j = 0; j < SET_BITS; j++) begin
      if (used == SIZE_W'(j)) cs_n = full_addr[BASE_W+j];
    end
  end
endmodule

// File: rtl/chargen_out_reg.sv
module chargen_out_reg #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              cs_n_d,
  output logic [ADDR_W-1:0] addr_q,
  output logic              cs_n_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cs_n_q <= 1'b1;
    end else if (load) begin
      addr_q <= addr_d;
      cs_n_q <= cs_n_d;
    end
  end
endmodule

// File: rtl/chargen_addresser.sv
module chargen_addresser
  import chargen_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int LINE_W = 4,
  localparam int BASE_W = CODE_W - 1 + LINE_W,
  localparam int ADDR_W = BASE_W + SET_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_en,
  input  logic [CODE_W-1:0] code_in,
  input  logic              enh_in,
  input  logic [LINE_W-1:0] scan_line,
  input  logic [SIZE_W-1:0] rom_size,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_cs_n
);
  logic [ADDR_W-1:0] full_addr;
  logic [ADDR_W-1:0] sized_addr;
  logic              sized_cs_n;

  chargen_addr_compose #(.CODE_W(CODE_W), .LINE_W(LINE_W)) compose_i (
    .code(code_in), .enh(enh_in), .line(scan_line), .full_addr(full_addr)
  );

  chargen_size_mask #(.BASE_W(BASE_W)) mask_i (
    .full_addr(full_addr), .size_sel(rom_size),
    .rom_addr(sized_addr), .cs_n(sized_cs_n)
  );

  chargen_out_reg #(.ADDR_W(ADDR_W)) out_i (
    .clk(clk), .rst(rst), .load(char_en),
    .addr_d(sized_addr), .cs_n_d(sized_cs_n),
    .addr_q(rom_addr), .cs_n_q(rom_cs_n)
  );
endmodule

// File: rtl/chargen_addresser_chk.sv
module chargen_addresser_chk #(
  parameter int CODE_W = 8,
  parameter int LINE_W = 4,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              char_en,
  input logic [CODE_W-1:0] code_in,
  input logic              enh_in,
  input logic [LINE_W-1:0] scan_line,
  input logic [1:0]        rom_size,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              rom_cs_n
);
  localparam int G = CODE_W - 1;
  localparam int B = G + LINE_W;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (rom_addr == '0) && rom_cs_n);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !char_en |=> $stable(rom_addr) && $stable(rom_cs_n));

  a_r3_glyph_and_line: assert property (@(posedge clk) disable iff (rst)
    char_en |=> (rom_addr[G-1:0] == $past(code_in[G-1:0])) &&
                (rom_addr[B-1:G] == $past(scan_line)));

  a_r4_one_set: assert property (@(posedge clk) disable iff (rst)
    (char_en && rom_size == 2'd0) |=>
      (rom_addr[B+1:B] == 2'b00) && (rom_cs_n == $past(code_in[CODE_W-1])));

  a_r5_two_set: assert property (@(posedge clk) disable iff (rst)
    (char_en && rom_size == 2'd1) |=>
      (rom_addr[B] == $past(code_in[CODE_W-1])) && !rom_addr[B+1] &&
      (rom_cs_n == !$past(enh_in)));

  a_r6_r7_four_set: assert property (@(posedge clk) disable iff (rst)
    (char_en && rom_size[1]) |=>
      (rom_addr[B] == $past(code_in[CODE_W-1])) &&
      (rom_addr[B+1] == !$past(enh_in)) && !rom_cs_n);
endmodule

bind chargen_addresser chargen_addresser_chk #(
  .CODE_W(CODE_W), .LINE_W(LINE_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .char_en(char_en), .code_in(code_in),
  .enh_in(enh_in), .scan_line(scan_line), .rom_size(rom_size),
  .rom_addr(rom_addr), .rom_cs_n(rom_cs_n)
);

// File: tb/chargen_addresser_tb_top.sv
module chargen_addresser_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        char_en = 1'b0;
  logic [7:0]  code_in = '0;
  logic        enh_in = 1'b0;
  logic [3:0]  scan_line = '0;
  logic [1:0]  rom_size = '0;
  logic [12:0] rom_addr;
  logic        rom_cs_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chargen_addresser dut_i (
    .clk(clk), .rst(rst), .char_en(char_en), .code_in(code_in),
    .enh_in(enh_in), .scan_line(scan_line), .rom_size(rom_size),
    .rom_addr(rom_addr), .rom_cs_n(rom_cs_n)
  );

  // behavioural model
  int    exp_addr = 0;
  int    exp_cs = 1;
  int    loaded_size = 0;
  string tag = "R1";
  bit    model_valid = 0;

  always @(posedge clk) begin
    if (rst) begin
      exp_addr = 0; exp_cs = 1; tag = "R1"; model_valid = 1;
    end else if (char_en) begin
      int sz, w, full;
      sz = (rom_size > 2) ? 2 : int'(rom_size);
      w = 11 + sz;
      full = (enh_in ? 0 : 4096) + (code_in[7] ? 2048 : 0)
           + int'(scan_line) * 128 + int'(code_in[6:0]);
      exp_addr = full % (1 << w);
      exp_cs = (w < 13) ? ((full >> w) & 1) : 0;
      loaded_size = int'(rom_size);
      case (rom_size)
        2'd0: tag = "R4";
        2'd1: tag = "R5";
        2'd2: tag = "R6";
        default: tag = "R7";
      endcase
    end else begin
      tag = (int'(rom_size) != loaded_size) ? "R8" : "R2";
    end
  end

  always @(negedge clk) begin
    if (model_valid && !done) begin
      string t;
      checks++;
      t = tag;
      if (tag != "R1" && tag != "R2" && tag != "R8" &&
          int'(rom_addr[10:0]) != exp_addr % 2048)
        t = "R3";
      if (int'(rom_addr) != exp_addr || int'(rom_cs_n) != exp_cs) begin
        fails++;
        $display("FAIL %s: addr=%0h cs_n=%0d expected addr=%0h cs_n=%0d",
                 t, rom_addr, rom_cs_n, exp_addr, exp_cs);
      end
    end
  end

  task automatic step(input bit en, input logic [7:0] c, input bit e,
                      input logic [3:0] l, input logic [1:0] s);
    @(negedge clk);
    char_en = en; code_in = c; enh_in = e; scan_line = l; rom_size = s;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // directed corners for each size (R4..R7), both set-bit polarities
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 4; b++) begin
        step(1, {b[0], 7'h41}, b[1], 4'hA, s[1:0]);
        step(0, 8'hFF, ~b[1], 4'h5, 2'(s + 1));  // R8: changes while idle
        step(0, 8'h00, b[1], 4'h3, 2'(s + 2));
      end
    // control codes and full scan range (R3)
    for (int c = 0; c < 32; c++) step(1, 8'(c), c[0], 4'(c), 2'(c >> 3));
    // random stream with idle gaps
    for (int i = 0; i < 4000; i++)
      step(($urandom % 3) != 0, 8'($urandom), 1'($urandom),
           4'($urandom), 2'($urandom));
    // mid-stream reset (R1)
    step(1, 8'hC3, 0, 4'hF, 2'd2);
    rst = 1'b1;
    step(1, 8'h7F, 1, 4'h1, 2'd1);
    rst = 1'b0;
    step(0, 8'h00, 0, 4'h0, 2'd0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule